// File: doc/BRIEF.md
# Debug Trace Message Serializer

This block turns watchpoint hits into fixed-length debug trace messages and shifts them out over a narrow trace port. Each hit carries the number of the watchpoint that fired. The hit is held in a small first-in first-out queue until the serializer is free. The serializer then sends the packed message two bits per beat, least significant bit first. A single framing line marks the end of every message, and an output clock qualifies both the data and the framing line.

When hits arrive faster than the port can drain them, a hit that finds the queue full is thrown away and an overrun flag is set. As soon as a slot frees up, one error message takes that slot, so the receiver learns that watchpoint messages were lost. Any stall of the requesting processor that limits overruns is handled outside this block. Overruns can still happen, so this error path is always present.

Top module: `trace_msg_ser`

## Requirements
- R1: With no message in progress, including right after reset, `mseo` is 1 and `mdo` is 00.
- R2: `mcko` is 0 in reset and toggles on every `clk` cycle after it. `mdo` and `mseo` change only on the clock edge at which `mcko` falls. Each beat therefore lasts two cycles, and its value is the same in the low half and the high half of `mcko`.
- R3: A watchpoint message is 16 bits. Bits [5:0] hold transfer code 15, bits [9:6] hold source 0, and bits [15:10] hold the watchpoint number. Beat k carries bits [2k+1:2k], with the lower bit on `mdo[0]`.
- R4: A message takes 8 beats. `mseo` is 0 on every beat but the last and 1 on the last beat. The beat after the last beat is an idle beat with `mseo` at 1, before any next message starts.
- R5: An overrun error message uses bits [5:0] for transfer code 8, bits [9:6] for source 0, bits [14:10] for error code 6, and bit 15 as a zero pad. Beats are laid out as in R3.
- R6: The queue holds 4 entries, and messages leave in the order their hits were accepted.
- R7: A hit that arrives while the queue is full is dropped and sets the overrun flag. Further drops while the flag is set add no further message.
- R8: When the overrun flag is set and a slot is free, exactly one error message is queued behind the entries already held, and the flag clears. A hit presented in that same cycle is covered by that error message.
- R9: With the queue empty and the port idle, the first beat of a hit's message is valid in a high half of `mcko` no later than 4 cycles after the cycle in which the hit is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wp_hit | input | 1 | One-cycle pulse: a watchpoint fired |
| wp_num | input | 6 | Number of the watchpoint that fired |
| mcko | output | 1 | Trace output clock, half the block clock |
| mdo | output | 2 | Trace data, two message bits per beat |
| mseo | output | 1 | Framing: low within a message, high on its last beat and while idle |

## Verification
A beat becomes visible on the edge at which `mcko` falls and stays unchanged for two cycles. The monitor therefore samples at the falling edge of `clk`, where every output has settled. It treats the sample taken with `mcko` high as the beat, and compares it with the sample from the low half that came before it. The first beat of a message on an idle port is due 3 or 4 cycles after the hit, depending on the phase of `mcko`, and the bench counts cycles from the hit to that beat. A full message is compared against the scoreboard on its final beat, about 16 cycles after it starts. Overrun bursts are timed so that the hits all fall within the first message's 16 cycles, which makes the set of dropped hits independent of the `mcko` phase.

// File: rtl/trace_msg_ser.sv
module trace_msg_ser #(
  parameter int QDEPTH = 4,
  parameter int WPW    = 6,
  parameter int TCW    = 6,
  parameter int SRCW   = 4,
  parameter int ECW    = 5,
  parameter int TC_WP  = 15,
  parameter int TC_ERR = 8,
  parameter int EC_OVR = 6,
  parameter int SRC_ID = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wp_hit,
  input  logic [WPW-1:0] wp_num,
  output logic           mcko,
  output logic [1:0]     mdo,
  output logic           mseo
);
  localparam int WPMSGW    = TCW + SRCW + WPW;
  localparam int ERRMSGW   = TCW + SRCW + ECW;
  localparam int MSGW      = (WPMSGW > ERRMSGW) ? WPMSGW : ERRMSGW;
  localparam int WP_BEATS  = (WPMSGW + 1) / 2;
  localparam int ERR_BEATS = (ERRMSGW + 1) / 2;
  localparam int BCW       = $clog2(MSGW / 2 + 2);
  localparam int PW        = $clog2(QDEPTH);
  localparam int CW        = $clog2(QDEPTH + 1);

  logic [WPW:0]    q [QDEPTH];
  logic [PW-1:0]   rd, wr;
  logic [CW-1:0]   count;
  logic            ovf, gap;
  logic [BCW-1:0]  left;
  logic [MSGW-1:0] sh;

  logic            full, step, pop, push_err, push_wp, push;
  logic [WPW:0]    head;
  logic [MSGW-1:0] wp_vec, err_vec, ld;
  logic [BCW-1:0]  nbeats;

  assign full     = (count == CW'(QDEPTH));
  assign step     = mcko;
  assign pop      = step && (left == '0) && !gap && (count != '0);
  assign push_err = ovf && !full;
  assign push_wp  = wp_hit && !ovf && !full;
  assign push     = push_err || push_wp;

  assign head    = q[rd];
  assign wp_vec  = MSGW'({head[WPW-1:0], SRCW'(SRC_ID), TCW'(TC_WP)});
  assign err_vec = MSGW'({ECW'(EC_OVR), SRCW'(SRC_ID), TCW'(TC_ERR)});
  assign ld      = head[WPW] ? err_vec : wp_vec;
  assign nbeats  = head[WPW] ? BCW'(ERR_BEATS) : BCW'(WP_BEATS);

  always_ff @(posedge clk)
    if (push) q[wr] <= push_err ? {1'b1, {WPW{1'b0}}} : {1'b0, wp_num};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd    <= '0;
      wr    <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (push) wr <= (wr == PW'(QDEPTH - 1)) ? '0 : wr + 1'b1;
      if (pop)  rd <= (rd == PW'(QDEPTH - 1)) ? '0 : rd + 1'b1;
      count <= count + CW'(push) - CW'(pop);
      if (push_err)          ovf <= 1'b0;
      else if (wp_hit && full) ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcko <= 1'b0;
      mdo  <= 2'b00;
      mseo <= 1'b1;
      left <= '0;
      gap  <= 1'b0;
      sh   <= '0;
    end else begin
      mcko <= ~mcko;
      if (step) begin
        if (left != '0) begin
          mdo  <= sh[1:0];
          sh   <= sh >> 2;
          left <= left - 1'b1;
          mseo <= (left == BCW'(1));
          gap  <= (left == BCW'(1));
        end else if (gap) begin
          mdo  <= 2'b00;
          mseo <= 1'b1;
          gap  <= 1'b0;
        end else if (count != '0) begin
          mdo  <= ld[1:0];
          sh   <= ld >> 2;
          left <= nbeats - 1'b1;
          mseo <= 1'b0;
        end else begin
          mdo  <= 2'b00;
          mseo <= 1'b1;
        end
      end
    end
  end

  assert_beat_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mcko |=> ($stable(mdo) && $stable(mseo)));

  assert_end_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mseo) |=> ##1 mseo);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(QDEPTH));

  assert_drop_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_hit && full) |=> ovf);

  assert_err_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !full) |=> !ovf);
endmodule

// File: tb/tb_trace_msg_ser.sv
`timescale 1ns/1ps
module tb_trace_msg_ser;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wp_hit = 1'b0;
  logic [5:0] wp_num = '0;
  logic       mcko;
  logic [1:0] mdo;
  logic       mseo;

  int vectors = 0;
  int miscompares = 0;
  logic [6:0] expq[$];

  trace_msg_ser dut (
    .clk(clk), .rst_n(rst_n), .wp_hit(wp_hit), .wp_num(wp_num),
    .mcko(mcko), .mdo(mdo), .mseo(mseo)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor / scoreboard
  logic [15:0] acc;
  int          nb = 0;
  bit          in_msg = 0, need_gap = 0, have_lo = 0;
  logic [1:0]  lo_mdo;
  logic        lo_mseo, prev_mcko;
  logic [6:0]  e;

  always @(negedge clk) begin
    if (rst_n) begin
      if (have_lo) chk(mcko != prev_mcko, "R2 mcko toggle", mcko, !prev_mcko);
      if (!mcko) begin
        lo_mdo = mdo; lo_mseo = mseo; have_lo = 1;
      end else if (have_lo) begin
        chk({lo_mdo, lo_mseo} == {mdo, mseo}, "R2 beat hold", {mdo, mseo}, {lo_mdo, lo_mseo});
        if (in_msg) begin
          acc[2*nb +: 2] = mdo;
          nb++;
          if (mseo) begin
            in_msg = 0;
            need_gap = 1;
            chk(nb == 8, "R4 message length", nb, 8);
            if (expq.size() == 0) chk(0, "R6 unexpected message", acc, 0);
            else begin
              e = expq.pop_front();
              if (e[6]) begin
                chk(acc[5:0] == 6'd8, "R5 transfer code", acc[5:0], 8);
                chk(acc[9:6] == 4'd0, "R5 source", acc[9:6], 0);
                chk(acc[14:10] == 5'd6, "R5 error code", acc[14:10], 6);
                chk(acc[15] == 1'b0, "R5 pad bit", acc[15], 0);
              end else begin
                chk(acc[5:0] == 6'd15, "R3 transfer code", acc[5:0], 15);
                chk(acc[9:6] == 4'd0, "R3 source", acc[9:6], 0);
                chk(acc[15:10] == e[5:0], "R3/R6 watchpoint number in order", acc[15:10], e[5:0]);
              end
            end
          end
        end else begin
          if (need_gap) begin
            chk(mseo == 1'b1, "R4 idle beat after end", mseo, 1);
            need_gap = 0;
          end
          if (!mseo) begin
            acc = '0;
            acc[1:0] = mdo;
            nb = 1;
            in_msg = 1;
          end else begin
            chk(mdo == 2'b00, "R1 idle data", mdo, 0);
          end
        end
      end
      prev_mcko = mcko;
    end
  end

  task automatic hit(input int n, input bit kept);
    @(negedge clk);
    wp_hit = 1'b1;
    wp_num = n[5:0];
    if (kept) expq.push_back({1'b0, n[5:0]});
  endtask

  task automatic quiet(input int c);
    @(negedge clk);
    wp_hit = 1'b0;
    repeat (c) @(negedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    int lat;
    repeat (4) @(negedge clk);
    chk(mseo == 1'b1, "R1 reset mseo", mseo, 1);
    chk(mdo == 2'b00, "R1 reset mdo", mdo, 0);
    chk(mcko == 1'b0, "R2 reset mcko", mcko, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(mseo == 1'b1, "R1 idle after reset", mseo, 1);

    // R9: latency on an idle port
    @(negedge clk);
    wp_hit = 1'b1; wp_num = 6'd5; expq.push_back({1'b0, 6'd5});
    lat = 0;
    do begin
      @(negedge clk);
      wp_hit = 1'b0;
      lat++;
    end while (!(mcko && !mseo) && lat < 10);
    chk(lat <= 4, "R9 first beat latency", lat, 4);
    quiet(60);

    // R3 boundary watchpoint numbers
    hit(0, 1);  quiet(40);
    hit(63, 1); quiet(40);
    hit(42, 1); hit(21, 1); quiet(80);

    // R6/R7/R8: overrun burst
    hit(9, 1); quiet(6);
    hit(10, 1); hit(11, 1); hit(12, 1); hit(13, 1);
    hit(20, 0); hit(21, 0); hit(22, 0);
    expq.push_back(7'b1000000);
    quiet(200);
    chk(expq.size() == 0, "R8 burst drained with one error", expq.size(), 0);

    // Normal traffic after recovery: no extra error message (R8)
    hit(30, 1); quiet(60);
    chk(expq.size() == 0, "R8 recovered without repeat error", expq.size(), 0);

    // Second overrun
    hit(1, 1); quiet(5);
    hit(2, 1); hit(3, 1); hit(4, 1); hit(5, 1); hit(6, 0);
    expq.push_back(7'b1000000);
    quiet(200);
    chk(expq.size() == 0, "R6 all expected messages delivered", expq.size(), 0);
    chk(mseo == 1'b1, "R1 idle at end", mseo, 1);
    summary();
  end
endmodule